// File: doc/BRIEF.md
# Register-Driven TMDS Pixel Encoder

This block is a register-mapped helper that turns packed colour words into 10-bit DVI video-data symbols for three lanes. Software loads a configuration register and a 32-bit colour word. It then reads back encoded symbols. A single-pixel read returns one symbol for each of the three lanes packed into one word. A double-pixel read returns two successive symbols for one chosen lane.

Each lane takes its 8-bit colour value from the low 16 bits of the colour word. It uses its own rotate amount and its own count of valid most-significant bits. Each lane keeps its own running DC disparity, so successive symbols stay DC balanced. Every read address comes as a pair. The peek address shows the result without touching any state. The pop address returns the same value, then commits the new disparity and shifts the colour word so that the next pixel is ready.

The bus is word-addressed. Writes take effect at the clock edge. Read data is combinational from the read address in the same cycle, and pop side effects take effect at the edge that ends the read.

Top module: `tmds_reg_encoder`

## Requirements
- R1: After reset the configuration register, the colour word and all three lane disparities are zero. Peeking a single pixel then returns the encoding of three zero colour values starting from zero disparity.
- R2: Word address 0 is the configuration register. Its fields are: bit 28 clear-balance (a strobe, not stored); bit 27 double no-shift; bits 26:24 shift select; bit 23 interleave; bits 20:18, 17:15 and 14:12 the bit counts n for lanes 2, 1 and 0; bits 11:8, 7:4 and 3:0 the rotate amounts for lanes 2, 1 and 0. Word address 1 loads the colour word. For each lane, the low 16 bits of the colour word are rotated right by that lane's rotate amount. Bits 15:8 of the result form the lane value. Only its n+1 top bits are kept and the rest are forced to zero, so n=0 keeps 1 bit and n=7 keeps 8 bits.
- R3: Each symbol follows the standard DVI video-data encoding. First the symbol chooses XOR or XNOR transition minimisation from the count of ones. Then it chooses inversion from the sign of the running disparity. The disparity is updated after each symbol, and a later symbol in the same read builds on the disparity left by the earlier one.
- R4: Single reads use address 2 (peek) and address 3 (pop). With interleave clear, lane 0 sits in bits 9:0, lane 1 in bits 19:10 and lane 2 in bits 29:20. Bits 31:30 always read zero.
- R5: With interleave set, a single read returns the three symbols bit-interleaved: bit 3*i+k of the word holds bit i of lane k's symbol, and bits 31:30 read zero.
- R6: A peek read changes neither the colour word nor any disparity. Two peeks in a row return the same word, and a pop that follows returns that same word too.
- R7: A single pop commits the disparity of all three lanes and shifts the colour word right, filling with zeros. The shift amount for select s is 0 bits for s=0, 2^(s-1) bits for s=1..5, and 32 bits (the word becomes zero) for s=6 or 7. A colour write in the same cycle takes priority over the shift.
- R8: Double reads for lane k use address 4+2k (peek) and 5+2k (pop). The first symbol sits in bits 9:0 and is taken from the current colour word. The second symbol sits in bits 19:10 and is taken from the colour word after one shift step. Bits 31:20 read zero.
- R9: With double no-shift set, both symbols of a double read are taken from the current colour word. A double pop then advances the colour word by one shift step, and by two steps when no-shift is clear.
- R10: A double pop commits the disparity left after both symbols for its own lane only. The other two lanes keep their disparity.
- R11: Writing the configuration register with bit 28 set resets all three disparities to zero. This clear wins over a pop in the same cycle.
- R12: When no read is requested, read data is zero. Reads from addresses 10 to 15 return zero, and writes to addresses 2 to 15 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Word address of the write |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe (one access per cycle) |
| rdAddr | input | ADDR_W | Word address of the read |
| rdData | output | 32 | Read data, valid in the same cycle as rdEn |

## Verification
The encoder is tried with all-zero colour and with fixed hand-picked words under mixed rotate and bit-count settings. These show whether extraction and masking pick the right bits for each lane. A long pseudo-random run mixes colour words, configurations and all read addresses, and checks every cycle against a behavioural model. It drives the disparity through both signs and through the balanced case, so a wrong inversion rule or a lost commit shows up in later symbols. Dedicated passes cover interleaved packing, no-shift double reads, the lane isolation of double pops, repeated peeks, clear-balance and unmapped addresses.

// File: rtl/tmds_enc_pkg.sv
package tmds_enc_pkg;
  localparam int LANES  = 3;
  localparam int SYM_W  = 10;
  localparam int ROT_W  = 4;
  localparam int NB_W   = 3;
  localparam int SH_W   = 3;
  localparam int DATA_W = 32;
  localparam int DISP_W = 6;
  localparam int COL_W  = 8;

  typedef logic signed [DISP_W-1:0] disp_t;

  typedef struct packed {
    logic [LANES-1:0][ROT_W-1:0] rot;
    logic [LANES-1:0][NB_W-1:0]  nbits;
    logic                        interleave;
    logic                        noShift;
    logic [SH_W-1:0]             shiftSel;
  } cfg_t;

  typedef struct packed {
    logic             clearBal;
    logic             commitSingle;
    logic [LANES-1:0] commitLane;
  } strobe_t;

  typedef struct packed {
    logic             single;
    logic [LANES-1:0] laneSel;
  } rdsel_t;

  typedef struct packed {
    logic [SYM_W-1:0] sym;
    disp_t            disp;
  } enc_t;

  // One shift step of the colour word for a given select code.
  function automatic logic [DATA_W-1:0] shiftOnce(input logic [DATA_W-1:0] c,
                                                  input logic [SH_W-1:0] sel);
    logic [5:0] amt;
    if (sel == '0) begin
      amt = 6'd0;
    end else if (sel >= SH_W'(6)) begin
      amt = 6'd32;
    end else begin
      amt = 6'd1 << (sel - SH_W'(1));
    end
    return (amt >= 6'd32) ? '0 : (c >> amt);
  endfunction

  // Rotate the low half-word and keep the requested number of top bits.
  function automatic logic [COL_W-1:0] extractLane(input logic [DATA_W-1:0] c,
                                                   input logic [ROT_W-1:0] rot,
                                                   input logic [NB_W-1:0] nb);
    logic [15:0] lo;
    logic [15:0] rr;
    logic [COL_W-1:0] mask;
    lo   = c[15:0];
    rr   = (lo >> rot) | (lo << (5'd16 - {1'b0, rot}));
    mask = 8'hFF << (NB_W'(7) - nb);
    return rr[15:8] & mask;
  endfunction

  // Video-data symbol with running disparity update.
  function automatic enc_t tmdsEncode(input logic [COL_W-1:0] d, input disp_t dispIn);
    logic [8:0] qm;
    logic useXnor;
    int n1, bal, dI;
    enc_t r;
    n1 = $countones(d);
    useXnor = (n1 > 4) || (n1 == 4 && !d[0]);
    qm[0] = d[0];
    for (int i = 1; i < 8; i++) begin
      qm[i] = useXnor ? ~(qm[i-1] ^ d[i]) : (qm[i-1] ^ d[i]);
    end
    qm[8] = ~useXnor;
    bal = 2 * $countones(qm[7:0]) - 8;
    dI  = int'(dispIn);
    if (dI == 0 || bal == 0) begin
      r.sym  = {~qm[8], qm[8], qm[8] ? qm[7:0] : ~qm[7:0]};
      r.disp = disp_t'(qm[8] ? dI + bal : dI - bal);
    end else if ((dI > 0 && bal > 0) || (dI < 0 && bal < 0)) begin
      r.sym  = {1'b1, qm[8], ~qm[7:0]};
      r.disp = disp_t'(dI + (qm[8] ? 2 : 0) - bal);
    end else begin
      r.sym  = {1'b0, qm[8], qm[7:0]};
      r.disp = disp_t'(dI - (qm[8] ? 0 : 2) + bal);
    end
    return r;
  endfunction
endpackage

// File: rtl/tmds_ctrl.sv
module tmds_ctrl
  import tmds_enc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output cfg_t              cfg,
  output logic [DATA_W-1:0] colour,
  output strobe_t           strobe,
  output rdsel_t            rdSel
);
  localparam logic [ADDR_W-1:0] ADR_CFG  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_COL  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_ONE  = ADDR_W'(2);
  localparam int               LANE_BASE = 2;

  logic cfgWr, colWr, isPop;
  logic [DATA_W-1:0] stepOne, stepTwo;

  assign cfgWr = wrEn && (wrAddr == ADR_CFG);
  assign colWr = wrEn && (wrAddr == ADR_COL);
  assign isPop = rdAddr[0];

  always_comb begin
    rdSel.single = rdEn && (rdAddr[ADDR_W-1:1] == ADR_ONE[ADDR_W-1:1]);
    for (int l = 0; l < LANES; l++) begin
      rdSel.laneSel[l] = rdEn && (rdAddr[ADDR_W-1:1] == (ADDR_W-1)'(LANE_BASE + l));
    end
    strobe.clearBal     = cfgWr && wrData[28];
    strobe.commitSingle = rdSel.single && isPop;
    strobe.commitLane   = rdSel.laneSel & {LANES{isPop}};
  end

  assign stepOne = shiftOnce(colour, cfg.shiftSel);
  assign stepTwo = shiftOnce(stepOne, cfg.shiftSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg    <= '0;
      colour <= '0;
    end else begin
      if (cfgWr) begin
        cfg.noShift    <= wrData[27];
        cfg.shiftSel   <= wrData[26:24];
        cfg.interleave <= wrData[23];
        for (int l = 0; l < LANES; l++) begin
          cfg.nbits[l] <= wrData[12 + NB_W*l +: NB_W];
          cfg.rot[l]   <= wrData[ROT_W*l +: ROT_W];
        end
      end
      if (colWr) begin
        colour <= wrData;
      end else if (strobe.commitSingle) begin
        colour <= stepOne;
      end else if (|strobe.commitLane) begin
        colour <= cfg.noShift ? stepOne : stepTwo;
      end
    end
  end

  // R6: a peek with no write leaves the colour word alone
  a_r6_peek_keeps_colour: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !rdAddr[0] && !wrEn) |=> $stable(colour));

  // R7: a pop with a zero shift select leaves the colour word alone
  a_r7_zero_shift_holds: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr[0] && !wrEn && cfg.shiftSel == '0) |=> $stable(colour));

  // R12: writes to unmapped addresses leave configuration and colour alone
  a_r12_unmapped_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr > ADR_COL && !rdEn) |=> ($stable(colour) && $stable(cfg)));
endmodule

// File: rtl/tmds_datapath.sv
module tmds_datapath
  import tmds_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfg_t              cfg,
  input  logic [DATA_W-1:0] colour,
  input  strobe_t           strobe,
  input  rdsel_t            rdSel,
  output logic [DATA_W-1:0] rdData
);
  localparam int PACK_W = LANES * SYM_W;

  logic [DATA_W-1:0] colourB;
  disp_t dispQ [LANES];
  enc_t  encA  [LANES];
  enc_t  encB  [LANES];
  logic [PACK_W-1:0] packPlain, packIl;

  assign colourB = cfg.noShift ? colour : shiftOnce(colour, cfg.shiftSel);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [COL_W-1:0] valA, valB;
    assign valA = extractLane(colour,  cfg.rot[g], cfg.nbits[g]);
    assign valB = extractLane(colourB, cfg.rot[g], cfg.nbits[g]);
    assign encA[g] = tmdsEncode(valA, dispQ[g]);
    assign encB[g] = tmdsEncode(valB, encA[g].disp);
    assign packPlain[g*SYM_W +: SYM_W] = encA[g].sym;

    // R3: each update adds an even amount, so the disparity stays even
    a_r3_disp_even: assert property (@(posedge clk) disable iff (!rstN)
      dispQ[g][0] == 1'b0);

    // R10: a double pop for another lane leaves this lane's disparity alone
    a_r10_lane_isolated: assert property (@(posedge clk) disable iff (!rstN)
      ((|strobe.commitLane) && !strobe.commitLane[g] && !strobe.clearBal)
        |=> $stable(dispQ[g]));
  end

  always_comb begin
    packIl = '0;
    for (int i = 0; i < SYM_W; i++) begin
      for (int l = 0; l < LANES; l++) begin
        packIl[LANES*i + l] = encA[l].sym[i];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdSel.single) begin
      rdData = {{(DATA_W-PACK_W){1'b0}}, cfg.interleave ? packIl : packPlain};
    end
    for (int l = 0; l < LANES; l++) begin
      if (rdSel.laneSel[l]) begin
        rdData = {{(DATA_W-2*SYM_W){1'b0}}, encB[l].sym, encA[l].sym};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int l = 0; l < LANES; l++) dispQ[l] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (strobe.clearBal) begin
          dispQ[l] <= '0;
        end else if (strobe.commitSingle) begin
          dispQ[l] <= encA[l].disp;
        end else if (strobe.commitLane[l]) begin
          dispQ[l] <= encB[l].disp;
        end
      end
    end
  end

  // R11: clear-balance zeroes every lane on the next edge
  a_r11_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearBal |=> (dispQ[0] == '0 && dispQ[1] == '0 && dispQ[2] == '0));

  // R6: with no commit or clear strobe, no disparity moves
  a_r6_no_strobe_stable: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> ($stable(dispQ[0]) && $stable(dispQ[1]) && $stable(dispQ[2])));

  // R4: the two top bits of read data are always zero
  a_r4_top_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:DATA_W-2] == 2'b00);

  // R12: no read selected means zero read data
  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == '0) |-> (rdData == '0));
endmodule

// File: rtl/tmds_reg_encoder.sv
module tmds_reg_encoder
  import tmds_enc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData
);
  cfg_t              cfg;
  logic [DATA_W-1:0] colour;
  strobe_t           strobe;
  rdsel_t            rdSel;

  tmds_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr),
    .cfg(cfg), .colour(colour), .strobe(strobe), .rdSel(rdSel)
  );

  tmds_datapath u_dp (
    .clk(clk), .rstN(rstN),
    .cfg(cfg), .colour(colour), .strobe(strobe), .rdSel(rdSel),
    .rdData(rdData)
  );
endmodule

// File: tb/tmds_reg_encoder_test.sv
`timescale 1ns/1ps
module tmds_reg_encoder_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic rdEn = 1'b0;
  logic [3:0] rdAddr = '0;
  logic [31:0] rdData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmds_reg_encoder uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  // Behavioural model state
  logic [31:0] mColour = '0;
  int mDisp[3] = '{0, 0, 0};
  int mRot[3]  = '{0, 0, 0};
  int mNb[3]   = '{0, 0, 0};
  int mSh = 0;
  bit mNoSh = 0, mIl = 0;
  logic [31:0] seed = 32'h1F2E3D4C;

  function automatic logic [31:0] nextRand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [31:0] mShift(input logic [31:0] c);
    if (mSh == 0) return c;
    if (mSh >= 6) return 32'd0;
    return c >> (1 << (mSh - 1));
  endfunction

  function automatic int mExtract(input logic [31:0] c, input int lane);
    int v, r, top, keep;
    v = c & 32'hFFFF;
    r = mRot[lane];
    v = ((v >> r) | (v << (16 - r))) & 16'hFFFF;
    top = (v >> 8) & 8'hFF;
    keep = mNb[lane] + 1;
    return top & ((255 << (8 - keep)) & 255);
  endfunction

  function automatic void mEnc(input int d, inout int disp, output int sym);
    int ones, q, prev, b, hi, bal;
    bit xn;
    ones = 0;
    for (int i = 0; i < 8; i++) ones += (d >> i) & 1;
    xn = (ones > 4) || (ones == 4 && (d & 1) == 0);
    prev = d & 1;
    q = prev;
    for (int i = 1; i < 8; i++) begin
      b = prev ^ ((d >> i) & 1);
      if (xn) b = 1 - b;
      q = q | (b << i);
      prev = b;
    end
    hi = xn ? 0 : 1;
    ones = 0;
    for (int i = 0; i < 8; i++) ones += (q >> i) & 1;
    bal = ones - (8 - ones);
    if (disp == 0 || bal == 0) begin
      sym = ((1 - hi) << 9) | (hi << 8) | (hi != 0 ? q : (~q & 255));
      disp = disp + (hi != 0 ? bal : -bal);
    end else if ((disp > 0 && bal > 0) || (disp < 0 && bal < 0)) begin
      sym = 512 | (hi << 8) | (~q & 255);
      disp = disp + 2 * hi - bal;
    end else begin
      sym = (hi << 8) | q;
      disp = disp + bal - 2 * (1 - hi);
    end
  endfunction

  function automatic logic [31:0] expRead(input int a);
    int s[3];
    int dd, s0, s1, l;
    logic [31:0] w;
    w = '0;
    if (a == 2 || a == 3) begin
      for (int k = 0; k < 3; k++) begin
        dd = mDisp[k];
        mEnc(mExtract(mColour, k), dd, s[k]);
      end
      if (mIl) begin
        for (int i = 0; i < 10; i++)
          for (int k = 0; k < 3; k++) w[3*i + k] = s[k][i];
      end else begin
        w = (s[2] << 20) | (s[1] << 10) | s[0];
      end
    end else if (a >= 4 && a <= 9) begin
      l = (a - 4) / 2;
      dd = mDisp[l];
      mEnc(mExtract(mColour, l), dd, s0);
      mEnc(mExtract(mNoSh ? mColour : mShift(mColour), l), dd, s1);
      w = (s1 << 10) | s0;
    end
    return w;
  endfunction

  task automatic applyPop(input int a);
    int sy, l, dd;
    if (a == 3) begin
      for (int k = 0; k < 3; k++) mEnc(mExtract(mColour, k), mDisp[k], sy);
      mColour = mShift(mColour);
    end else if (a == 5 || a == 7 || a == 9) begin
      l = (a - 4) / 2;
      dd = mDisp[l];
      mEnc(mExtract(mColour, l), dd, sy);
      mEnc(mExtract(mNoSh ? mColour : mShift(mColour), l), dd, sy);
      mDisp[l] = dd;
      mColour = mNoSh ? mShift(mColour) : mShift(mShift(mColour));
    end
  endtask

  task automatic applyWrite(input int a, input logic [31:0] d);
    if (a == 0) begin
      mNoSh = d[27];
      mSh = int'(d[26:24]);
      mIl = d[23];
      for (int k = 0; k < 3; k++) begin
        mNb[k]  = int'(d[12 + 3*k +: 3]);
        mRot[k] = int'(d[4*k +: 4]);
      end
      if (d[28]) for (int k = 0; k < 3; k++) mDisp[k] = 0;
    end else if (a == 1) begin
      mColour = d;
    end
  endtask

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: rdData=%h expected %h", tag, got, exp);
    end
  endtask

  // One clock: drive at the falling edge, compare, then advance the model.
  task automatic step(input bit we, input int wa, input logic [31:0] wd,
                      input bit re, input int ra, input string tag);
    logic [31:0] e;
    wrEn = we; wrAddr = 4'(wa); wrData = wd;
    rdEn = re; rdAddr = 4'(ra);
    #1;
    e = re ? expRead(ra) : 32'd0;
    check(rdData, e, tag);
    @(posedge clk);
    if (re) applyPop(ra);
    if (we) applyWrite(wa, wd);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d, input string tag);
    step(1'b1, a, d, 1'b0, 0, tag);
  endtask

  task automatic rd(input int a, input string tag);
    step(1'b0, 0, 32'd0, 1'b1, a, tag);
  endtask

  function automatic logic [31:0] cfgWord(input bit clr, input bit nosh, input int sh,
                                          input bit il, input int nb2, input int nb1,
                                          input int nb0, input int r2, input int r1,
                                          input int r0);
    return (32'(clr) << 28) | (32'(nosh) << 27) | (32'(sh) << 24) | (32'(il) << 23) |
           (32'(nb2) << 18) | (32'(nb1) << 15) | (32'(nb0) << 12) |
           (32'(r2) << 8) | (32'(r1) << 4) | 32'(r0);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] pk1, pk2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state, R12 idle
    step(1'b0, 0, 32'd0, 1'b0, 0, "R12 idle read zero");
    rd(2, "R1 reset single peek");
    rd(6, "R1 reset lane1 peek");

    // R2 extraction with mixed rotate and bit counts
    wr(0, cfgWord(0, 0, 3, 0, 0, 4, 7, 11, 5, 0), "R2 cfg write");
    wr(1, 32'h1234_5678, "R2 colour write");
    rd(2, "R2 extract peek");
    rd(3, "R7 single pop");
    rd(2, "R7 after shift");
    wr(1, 32'h0000_FF00, "R2 colour write");
    rd(2, "R2 full byte lane0");

    // R3/R7 pseudo-random sweep over colour, configuration and reads
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      int a;
      r = nextRand();
      if (r[3:0] == 0) wr(0, nextRand() & ~(32'h1 << 28) & ~(32'h1 << 23), "R3 cfg");
      else if (r[3:0] < 4) wr(1, nextRand(), "R3 colour");
      a = 2 + int'(r[11:8]) % 8;
      rd(a, (a % 2 == 1) ? "R7 R8 pop sweep" : "R3 R8 peek sweep");
    end

    // R5 interleaved packing
    wr(0, cfgWord(0, 0, 2, 1, 7, 5, 3, 2, 9, 15), "R5 cfg");
    wr(1, 32'hA5C3_96E1, "R5 colour");
    rd(2, "R5 interleave peek");
    rd(3, "R5 interleave pop");
    rd(2, "R5 interleave after pop");

    // R6 repeated peeks then pop equal
    wr(0, cfgWord(0, 0, 4, 0, 7, 7, 7, 0, 4, 8), "R6 cfg");
    wr(1, 32'hBEEF_1357, "R6 colour");
    rd(3, "R6 prime disparity");
    wrEn = 0; rdEn = 1; rdAddr = 4'd2; #1; pk1 = rdData;
    @(posedge clk); @(negedge clk); #1; pk2 = rdData;
    check(pk2, pk1, "R6 peek repeat");
    rdAddr = 4'd3; #1;
    check(rdData, pk1, "R6 pop equals peek");
    @(posedge clk); applyPop(3); @(negedge clk);
    rdEn = 0;
    rd(2, "R6 model after pop");

    // R8/R10 double reads and lane isolation
    wr(1, 32'h0F0F_3C3C, "R8 colour");
    rd(8, "R8 lane2 peek");
    rd(5, "R10 lane0 pop");
    rd(2, "R10 others unchanged");
    rd(7, "R10 lane1 pop");
    rd(9, "R10 lane2 pop");
    rd(2, "R10 single after lane pops");

    // R9 no-shift double
    wr(0, cfgWord(0, 1, 3, 0, 7, 6, 7, 3, 0, 12), "R9 cfg");
    wr(1, 32'hC0DE_7A11, "R9 colour");
    rd(4, "R9 noshift peek");
    rd(5, "R9 noshift pop");
    rd(4, "R9 after one step");
    wr(0, cfgWord(0, 0, 5, 0, 7, 6, 7, 3, 0, 12), "R9 cfg shift");
    rd(7, "R9 two step pop");
    rd(6, "R9 after two steps");

    // R11 clear balance, also with a simultaneous pop
    rd(3, "R11 build disparity");
    wr(0, cfgWord(1, 0, 0, 0, 7, 7, 7, 0, 0, 0), "R11 clear write");
    rd(2, "R11 peek after clear");
    step(1'b1, 0, cfgWord(1, 0, 0, 0, 7, 7, 7, 0, 0, 0), 1'b1, 3, "R11 clear with pop");
    rd(2, "R11 clear beats pop");

    // R7 large shift select zeroes the colour word; colour write beats pop
    wr(0, cfgWord(0, 0, 6, 0, 7, 7, 7, 0, 8, 4), "R7 cfg big shift");
    wr(1, 32'hFFFF_FFFF, "R7 colour");
    rd(3, "R7 big shift pop");
    rd(2, "R7 word cleared");
    step(1'b1, 1, 32'h0000_8181, 1'b1, 3, "R7 write with pop");
    rd(2, "R7 write priority");

    // R12 unmapped reads and writes
    wr(12, 32'hFFFF_FFFF, "R12 unmapped write");
    wr(2, 32'hFFFF_FFFF, "R12 write to read address");
    rd(2, "R12 state unchanged");
    for (int a = 10; a < 16; a++) rd(a, "R12 unmapped read");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule